// File: doc/BRIEF.md
# Page-Splitting Transmit Descriptor Builder

The block turns a chain of packet fragments into entries of a transmit descriptor ring. Each fragment comes in as a start address, a byte length and a flag that marks the last fragment of the frame. The block cuts every fragment at 4 KB page boundaries, so no descriptor buffer crosses a page. It writes one descriptor per piece, giving the ring index, a control word and the buffer address. When a whole frame has been laid down, it issues one tail-pointer update.

A consumer index from the transmit side tells the builder how far the ring has drained. Before each descriptor is written, the block checks whether the ring is full. On a full ring the frame is abandoned as a whole. The producer index is not moved, the rest of the frame's fragments are taken in and thrown away, a no-buffer counter steps up, and the free count drops to zero. The next frame then starts at the old producer index.

Control word layout: bits [15:0] hold the byte count, bit 28 marks the end of the table, bit 29 requests an interrupt on completion, bit 30 marks the end of the frame and bit 31 marks the start of the frame. All other bits are zero.

Top module: `txd_page_builder`

## Requirements
- R1: A fragment is written as one descriptor per 4 KB page it touches. The first piece starts at the fragment address and each later piece starts at a page base. No descriptor's byte count carries it past the end of its page.
- R2: A zero-length fragment yields no descriptor of its own. If the last fragment of a frame is zero-length and the frame already has descriptors, the final descriptor is written again at the same index, with the same address and with bits 30 and 29 added.
- R3: Bit 31 (start of frame) is set only on the piece that begins at the first fragment's start address. If the first fragment is zero-length, no descriptor of that frame carries it.
- R4: Bits 30 (end of frame) and 29 (interrupt) are always set together. They appear only on the piece that ends at the end of the last fragment.
- R5: Bit 28 (end of table) is set on a descriptor exactly when its ring index is RING_N-1.
- R6: If the next producer index equals cons_idx_i when a descriptor is due, the frame is abandoned. No tail update is issued, nobuf_cnt_o rises by one, free_cnt_o becomes 0, and the frame's remaining fragments are accepted and discarded without writes.
- R7: After an abandoned frame the producer index keeps the value it had before that frame, so the next frame's first descriptor lands at that index.
- R8: Once a frame is complete, a single tail update carries (new producer index) times DESC_BYTES. free_cnt_o becomes RING_N - ((producer - cons_idx_i) mod RING_N) - 1. Indices wrap modulo RING_N.
- R9: Every descriptor address equals the buffer address plus DATA_OFS.
- R10: After reset, free_cnt_o is RING_N-1, nobuf_cnt_o is 0, no write or tail strobe is active, and frag_ready_o is 1.
- R11: A frame that produced no descriptor issues no tail update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frag_valid_i | input | 1 | Fragment offered |
| frag_ready_o | output | 1 | Fragment taken on this edge when valid |
| frag_addr_i | input | AW | Fragment start address |
| frag_len_i | input | LW | Fragment length in bytes |
| frag_last_i | input | 1 | Fragment closes the frame |
| cons_idx_i | input | log2(RING_N) | Consumer ring index |
| desc_we_o | output | 1 | Descriptor write strobe |
| desc_idx_o | output | log2(RING_N) | Ring index of the write |
| desc_ctrl_o | output | 32 | Control word |
| desc_addr_o | output | AW | Buffer address plus offset |
| tail_we_o | output | 1 | Tail pointer update strobe |
| tail_ptr_o | output | log2(RING_N)+log2(DESC_BYTES) | New tail in bytes |
| free_cnt_o | output | log2(RING_N) | Free descriptor credits |
| nobuf_cnt_o | output | CNT_W | Abandoned frame count |

## Verification
The bench feeds single-fragment frames with different page offsets and lengths. These cover a piece that fits inside one page, a piece that exactly fills a page, a piece that starts on the last byte of a page, and pieces that span two, three and four pages. Together they separate off-by-one page arithmetic from correct splitting, and the run wraps the ring twice so that the end-of-table bit is exercised. Multi-fragment frames with zero-length first or last fragments separate start and end flag placement from the mere order of the pieces. Frames are also run against a nearly full ring and against a completely full ring, to show that rollback differs from a partial commit.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int CTRL_SOF = 31;
  localparam int CTRL_EOF = 30;
  localparam int CTRL_IOC = 29;
  localparam int CTRL_EOT = 28;
  localparam int CTRL_CNT_W = 16;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_DROP,
    ST_FIX,
    ST_COMMIT
  } bld_state_e;
endpackage

// File: rtl/txd_page_seg.sv
module txd_page_seg #(
  parameter int PAGE_BITS = 12,
  parameter int LW        = 16
) (
  input  logic [PAGE_BITS-1:0] addr_lo_i,
  input  logic [LW-1:0]        rem_i,
  output logic [LW-1:0]        seg_len_o,
  output logic                 seg_fin_o
);
  localparam int SPW = PAGE_BITS + 1;
  localparam logic [SPW-1:0] PAGE = SPW'(1) << PAGE_BITS;

  logic [SPW-1:0] space;
  logic [LW-1:0]  space_ext;

  assign space     = PAGE - SPW'(addr_lo_i);
  assign space_ext = LW'(space);
  assign seg_fin_o = rem_i <= space_ext;
  assign seg_len_o = seg_fin_o ? rem_i : space_ext;
endmodule

// File: rtl/txd_ctrl_pack.sv
module txd_ctrl_pack #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] len_i,
  input  logic          sof_i,
  input  logic          eof_i,
  input  logic          eot_i,
  output logic [31:0]   ctrl_o
);
  import txd_pkg::*;
  always_comb begin
    ctrl_o = '0;
    ctrl_o[CTRL_CNT_W-1:0] = CTRL_CNT_W'(len_i);
    ctrl_o[CTRL_SOF] = sof_i;
    ctrl_o[CTRL_EOF] = eof_i;
    ctrl_o[CTRL_IOC] = eof_i;
    ctrl_o[CTRL_EOT] = eot_i;
  end
endmodule

// File: rtl/txd_ring_idx.sv
module txd_ring_idx #(
  parameter int RING_N = 8,
  parameter int CNT_W  = 8,
  localparam int IW    = $clog2(RING_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] cons_i,
  input  logic          adv_i,
  input  logic          abort_i,
  input  logic          commit_i,
  output logic [IW-1:0] wr_o,
  output logic          full_o,
  output logic [IW-1:0] free_o,
  output logic [CNT_W-1:0] nobuf_o
);
  logic [IW-1:0]    prod_q, wr_q, free_q;
  logic [CNT_W-1:0] nobuf_q;

  assign full_o  = (wr_q + IW'(1)) == cons_i;
  assign wr_o    = wr_q;
  assign free_o  = free_q;
  assign nobuf_o = nobuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      wr_q    <= '0;
      free_q  <= IW'(RING_N - 1);
      nobuf_q <= '0;
    end else begin
      if (abort_i) begin
        wr_q    <= prod_q;
        free_q  <= '0;
        nobuf_q <= nobuf_q + CNT_W'(1);
      end else if (adv_i) begin
        wr_q <= wr_q + IW'(1);
      end
      if (commit_i) begin
        prod_q <= wr_q;
        free_q <= IW'(RING_N - 1) - (wr_q - cons_i);
      end
    end
  end

  a_r6_free_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> free_q == '0);
  a_r7_prod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> prod_q == $past(prod_q));
  a_r7_wr_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> wr_q == $past(prod_q));
endmodule

// File: rtl/txd_page_builder.sv
module txd_page_builder #(
  parameter int          RING_N     = 8,
  parameter int          AW         = 32,
  parameter int          LW         = 16,
  parameter int          PAGE_BITS  = 12,
  parameter int          DESC_BYTES = 8,
  parameter int          CNT_W      = 8,
  parameter logic [31:0] DATA_OFS   = 32'h8000_0000,
  localparam int IW = $clog2(RING_N),
  localparam int DB = $clog2(DESC_BYTES),
  localparam int TW = IW + DB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frag_valid_i,
  output logic             frag_ready_o,
  input  logic [AW-1:0]    frag_addr_i,
  input  logic [LW-1:0]    frag_len_i,
  input  logic             frag_last_i,
  input  logic [IW-1:0]    cons_idx_i,
  output logic             desc_we_o,
  output logic [IW-1:0]    desc_idx_o,
  output logic [31:0]      desc_ctrl_o,
  output logic [AW-1:0]    desc_addr_o,
  output logic             tail_we_o,
  output logic [TW-1:0]    tail_ptr_o,
  output logic [IW-1:0]    free_cnt_o,
  output logic [CNT_W-1:0] nobuf_cnt_o
);
  import txd_pkg::*;

  bld_state_e    st_q;
  logic          busy_q, last_q, first_q, sof_q, any_q;
  logic [AW-1:0] addr_q, laddr_q;
  logic [LW-1:0] rem_q;
  logic [31:0]   lctrl_q;
  logic [IW-1:0] lidx_q;

  logic          dwe_q, twe_q;
  logic [IW-1:0] didx_q;
  logic [31:0]   dctrl_q;
  logic [AW-1:0] daddr_q;
  logic [TW-1:0] tptr_q;

  logic          accept, seg_go, wr_go, abort, commit, full, seg_fin;
  logic [LW-1:0] seg_len;
  logic [IW-1:0] wr_idx;
  logic [31:0]   ctrl;

  assign frag_ready_o = (st_q == ST_RUN && !busy_q) || st_q == ST_DROP;
  assign accept = frag_valid_i && frag_ready_o;
  assign seg_go = st_q == ST_RUN && busy_q;
  assign wr_go  = seg_go && !full;
  assign abort  = seg_go && full;
  assign commit = st_q == ST_COMMIT;

  txd_page_seg #(.PAGE_BITS(PAGE_BITS), .LW(LW)) u_seg (
    .addr_lo_i (addr_q[PAGE_BITS-1:0]),
    .rem_i     (rem_q),
    .seg_len_o (seg_len),
    .seg_fin_o (seg_fin)
  );

  txd_ctrl_pack #(.LW(LW)) u_pack (
    .len_i  (seg_len),
    .sof_i  (sof_q),
    .eof_i  (last_q && seg_fin),
    .eot_i  (wr_idx == IW'(RING_N - 1)),
    .ctrl_o (ctrl)
  );

  txd_ring_idx #(.RING_N(RING_N), .CNT_W(CNT_W)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cons_i   (cons_idx_i),
    .adv_i    (wr_go),
    .abort_i  (abort),
    .commit_i (commit),
    .wr_o     (wr_idx),
    .full_o   (full),
    .free_o   (free_cnt_o),
    .nobuf_o  (nobuf_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      first_q <= 1'b1;
      sof_q   <= 1'b0;
      any_q   <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      laddr_q <= '0;
      lctrl_q <= '0;
      lidx_q  <= '0;
      dwe_q   <= 1'b0;
      didx_q  <= '0;
      dctrl_q <= '0;
      daddr_q <= '0;
      twe_q   <= 1'b0;
      tptr_q  <= '0;
    end else begin
      dwe_q <= 1'b0;
      twe_q <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (accept) begin
            first_q <= 1'b0;
            sof_q   <= first_q && (frag_len_i != '0);
            if (frag_len_i == '0) begin
              if (frag_last_i) begin
                if (any_q) st_q <= ST_FIX;
                else first_q <= 1'b1;  // empty frame: nothing to publish
              end
            end else begin
              busy_q <= 1'b1;
              last_q <= frag_last_i;
              addr_q <= frag_addr_i;
              rem_q  <= frag_len_i;
            end
          end
          if (wr_go) begin
            dwe_q   <= 1'b1;
            didx_q  <= wr_idx;
            dctrl_q <= ctrl;
            daddr_q <= addr_q + DATA_OFS[AW-1:0];
            lidx_q  <= wr_idx;
            lctrl_q <= ctrl;
            laddr_q <= addr_q + DATA_OFS[AW-1:0];
            sof_q   <= 1'b0;
            any_q   <= 1'b1;
            addr_q  <= addr_q + AW'(seg_len);
            rem_q   <= rem_q - seg_len;
            if (seg_fin) begin
              busy_q <= 1'b0;
              if (last_q) st_q <= ST_COMMIT;
            end
          end
          if (abort) begin
            busy_q <= 1'b0;
            any_q  <= 1'b0;
            if (last_q) first_q <= 1'b1;
            else        st_q    <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (accept && frag_last_i) begin
            st_q    <= ST_RUN;
            first_q <= 1'b1;
            any_q   <= 1'b0;
          end
        end
        ST_FIX: begin
          dwe_q   <= 1'b1;
          didx_q  <= lidx_q;
          dctrl_q <= lctrl_q | (32'd1 << CTRL_EOF) | (32'd1 << CTRL_IOC);
          daddr_q <= laddr_q;
          st_q    <= ST_COMMIT;
        end
        ST_COMMIT: begin
          twe_q   <= 1'b1;
          tptr_q  <= {wr_idx, {DB{1'b0}}};
          st_q    <= ST_RUN;
          first_q <= 1'b1;
          any_q   <= 1'b0;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign desc_we_o   = dwe_q;
  assign desc_idx_o  = didx_q;
  assign desc_ctrl_o = dctrl_q;
  assign desc_addr_o = daddr_q;
  assign tail_we_o   = twe_q;
  assign tail_ptr_o  = tptr_q;

  logic [PAGE_BITS-1:0] chk_off;
  logic [LW:0]          chk_span;
  assign chk_off  = desc_addr_o[PAGE_BITS-1:0] - DATA_OFS[PAGE_BITS-1:0];
  assign chk_span = (LW+1)'(chk_off) + (LW+1)'(desc_ctrl_o[CTRL_CNT_W-1:0]);

  a_r1_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> chk_span <= ((LW+1)'(1) << PAGE_BITS));
  a_r4_eof_ioc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> desc_ctrl_o[CTRL_EOF] == desc_ctrl_o[CTRL_IOC]);
  a_r5_eot_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> desc_ctrl_o[CTRL_EOT] == (desc_idx_o == IW'(RING_N - 1)));
  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_we_o && tail_we_o));
  a_r6_no_tail_on_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !tail_we_o);
endmodule

// File: tb/tb_txd_page_builder.sv
module tb_txd_page_builder;
  localparam int RN = 8;
  localparam logic [31:0] DOFS = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 1'b0, flast = 1'b0;
  logic [31:0] faddr = '0;
  logic [15:0] flen = '0;
  logic [2:0]  cons = '0;
  logic        frdy, dwe, twe;
  logic [2:0]  didx, free;
  logic [31:0] dctrl, daddr;
  logic [5:0]  tptr;
  logic [7:0]  nobuf;

  always #10 clk = ~clk;

  txd_page_builder #(.RING_N(RN), .DATA_OFS(DOFS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frag_valid_i(fv), .frag_ready_o(frdy),
    .frag_addr_i(faddr), .frag_len_i(flen), .frag_last_i(flast),
    .cons_idx_i(cons), .desc_we_o(dwe), .desc_idx_o(didx),
    .desc_ctrl_o(dctrl), .desc_addr_o(daddr), .tail_we_o(twe),
    .tail_ptr_o(tptr), .free_cnt_o(free), .nobuf_cnt_o(nobuf)
  );

  int total = 0, fails = 0;
  int cap_n = 0, tail_n = 0;
  logic [2:0]  cap_idx [32];
  logic [31:0] cap_ctrl [32];
  logic [31:0] cap_addr [32];
  logic [5:0]  last_tail;

  always @(negedge clk) begin
    if (dwe && cap_n < 32) begin
      cap_idx[cap_n] = didx; cap_ctrl[cap_n] = dctrl; cap_addr[cap_n] = daddr;
      cap_n = cap_n + 1;
    end
    if (twe) begin
      tail_n = tail_n + 1; last_tail = tptr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ectrl(input int cnt, input bit sof, input bit eof,
                                        input logic [2:0] idx);
    logic [31:0] c;
    c = 32'(cnt) & 32'h0000_FFFF;
    if (sof) c[31] = 1'b1;
    if (eof) begin c[30] = 1'b1; c[29] = 1'b1; end
    if (idx == 3'(RN - 1)) c[28] = 1'b1;
    return c;
  endfunction

  task automatic send(input logic [31:0] a, input logic [15:0] l, input bit last);
    @(negedge clk);
    fv = 1'b1; faddr = a; flen = l; flast = last;
    while (!frdy) @(negedge clk);
    @(negedge clk);
    fv = 1'b0;
  endtask

  task automatic start_frame(input logic [2:0] c);
    @(negedge clk);
    cons = c; cap_n = 0; tail_n = 0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic chk_desc(input string req, input int k, input logic [2:0] idx,
                          input logic [31:0] addr, input logic [31:0] ctrl);
    chk({req, " idx"}, 64'(cap_idx[k]), 64'(idx));
    chk({req, " addr"}, 64'(cap_addr[k]), 64'(addr + DOFS));
    chk({req, " ctrl"}, 64'(cap_ctrl[k]), 64'(ctrl));
  endtask

  // single-fragment frames: {addr, len}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0000_1000, 16'd64},
    {32'h0000_1FF0, 16'd32},
    {32'h0000_2000, 16'd4096},
    {32'h0000_2F00, 16'd8192},
    {32'h0000_3FFF, 16'd1},
    {32'h0000_4FFF, 16'd2},
    {32'h1234_5678, 16'd5000},
    {32'h0000_0800, 16'd12288}
  };

  logic [2:0] prod = '0;

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 free", 64'(free), 64'(RN - 1));
    chk("R10 nobuf", 64'(nobuf), 0);
    chk("R10 desc_we", 64'(dwe), 0);
    chk("R10 tail_we", 64'(twe), 0);
    chk("R10 ready", 64'(frdy), 1);

    // R1 R5 R8 R9: table walk, wraps the ring twice
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a, e, s, nb;
      int l, n;
      a = VEC[v][47:16]; l = int'(VEC[v][15:0]);
      n = int'((a + 32'(l) - 1) >> 12) - int'(a >> 12) + 1;
      start_frame(prod);
      send(a, 16'(l), 1'b1);
      settle();
      chk("R1 count", 64'(cap_n), 64'(n));
      for (int k = 0; k < n && k < 32; k++) begin
        s  = (k == 0) ? a : (((a >> 12) + 32'(k)) << 12);
        nb = ((s >> 12) + 1) << 12;
        e  = (nb < a + 32'(l)) ? nb : a + 32'(l);
        chk_desc("R1 R5 R9 seg", k, 3'(prod + 3'(k)), s,
                 ectrl(int'(e - s), k == 0, k == n - 1, 3'(prod + 3'(k))));
      end
      prod = 3'(prod + 3'(n));
      chk("R8 tail count", 64'(tail_n), 1);
      chk("R8 tail ptr", 64'(last_tail), 64'({prod, 3'b000}));
      chk("R8 free", 64'(free), 64'(RN - 1 - n));
    end

    // R2 R3: zero-length first and last fragments
    start_frame(prod);
    send(32'h0000_5000, 16'd0, 1'b0);
    send(32'h0000_6010, 16'd100, 1'b0);
    send(32'h0000_7000, 16'd0, 1'b1);
    settle();
    chk("R2 writes", 64'(cap_n), 2);
    chk_desc("R3 no sof", 0, prod, 32'h6010, ectrl(100, 0, 0, prod));
    chk_desc("R2 fixup", 1, prod, 32'h6010, ectrl(100, 0, 1, prod));
    prod = prod + 3'd1;
    chk("R2 tail", 64'(last_tail), 64'({prod, 3'b000}));

    // R3 R4: two fragments, first crosses a page
    start_frame(prod);
    send(32'h0000_9F00, 16'h200, 1'b0);
    send(32'h0000_B000, 16'h10, 1'b1);
    settle();
    chk("R4 writes", 64'(cap_n), 3);
    chk_desc("R3 sof first", 0, prod, 32'h9F00, ectrl(256, 1, 0, prod));
    chk_desc("R4 middle", 1, 3'(prod + 3'd1), 32'hA000, ectrl(256, 0, 0, 3'(prod + 3'd1)));
    chk_desc("R4 eof last", 2, 3'(prod + 3'd2), 32'hB000, ectrl(16, 0, 1, 3'(prod + 3'd2)));
    prod = prod + 3'd3;
    chk("R8 tail", 64'(last_tail), 64'({prod, 3'b000}));

    // R11: frame of only a zero-length fragment
    start_frame(prod);
    send(32'h0000_C000, 16'd0, 1'b1);
    settle();
    chk("R11 writes", 64'(cap_n), 0);
    chk("R11 tail", 64'(tail_n), 0);

    // R6: ring fills mid-frame; following fragment dropped
    start_frame(3'(prod + 3'd3));
    send(32'h0001_0000, 16'h4000, 1'b0);
    send(32'h0002_0000, 16'h40, 1'b1);
    settle();
    chk("R6 partial writes", 64'(cap_n), 2);
    chk("R6 no tail", 64'(tail_n), 0);
    chk("R6 nobuf", 64'(nobuf), 1);
    chk("R6 free zero", 64'(free), 0);

    // R6: full on first descriptor of a single-fragment frame
    start_frame(3'(prod + 3'd1));
    send(32'h0003_0000, 16'h20, 1'b1);
    settle();
    chk("R6 no write", 64'(cap_n), 0);
    chk("R6 nobuf 2", 64'(nobuf), 2);
    chk("R6 ready back", 64'(frdy), 1);

    // R7: next frame begins at the unchanged producer index
    start_frame(prod);
    send(32'h0004_0040, 16'h20, 1'b1);
    settle();
    chk("R7 writes", 64'(cap_n), 1);
    chk_desc("R7 rollback", 0, prod, 32'h0004_0040, ectrl(32, 1, 1, prod));
    prod = prod + 3'd1;
    chk("R7 tail", 64'(last_tail), 64'({prod, 3'b000}));
    chk("R8 free", 64'(free), 64'(RN - 2));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule